// File: doc/BRIEF.md
# Multi-Channel Memory Transfer Engine

This block moves data between addresses of a single 32-bit address space on behalf of several independent channels. Software programs each channel with a source address, a destination address, a limit address, the largest transfer width each side accepts, and whether each address steps forward after every packet. Setting the start bit then runs the channel until the transfer ends. The transfer ends when the limit is reached, when software clears the enable bit, or when the pacing device signals the end.

A channel runs in one of two pacing modes. In software pacing, packets follow one another as soon as the channel wins the shared memory port. In device pacing, a per-channel field selects one of several request/terminate port pairs. Packets then move only while that port requests. Channels wanting service are granted the memory port one packet at a time, lowest channel number first. Channel 0 also keeps a CRC-32 over every byte it writes.

Each packet takes a read cycle and then a write cycle on a simple memory port. Read data is returned one cycle after the read strobe. It is written out in the next cycle, right-aligned, using the same byte count.

Top module: `dma_engine`

## Requirements
- R1: There are seven channels, each with its own registers. The register address is {channel[2:0], select[2:0]}, where select 0=control, 1=source, 2=destination, 3=limit, 4=status and 5=CRC (channel 0 only). Control bits are: 0 enable, 1 start (write-only, reads 0), 2 device pacing, 3 source step, 4 destination step, [6:5] source width cap, [8:7] destination width cap, [11:9] pacing port index. Register writes read back as written.
- R2: Width codes are 0=1 byte, 1=2 bytes, 2 or 3=4 bytes. Each packet moves the smaller of the two capped widths on both the read and the write.
- R3: After a packet, an address whose step bit is set advances by the packet byte count. An address whose step bit is clear stays unchanged.
- R4: After a packet, the reference address is compared with the limit. The reference is the new source address when source step is set, and the new destination address otherwise. If the reference is greater than or equal to the limit, the channel goes idle and sets status bit 0 (done).
- R5: Clearing enable while a channel is busy stops it. A packet already in flight completes and its address updates are kept. No further packet follows, busy clears and status bit 1 (aborted) is set.
- R6: In device pacing, a high terminate input on the selected port ends the transfer. Busy clears and status bit 2 (terminated) is set.
- R7: In device pacing, a channel moves packets only while the request input of its selected port is high. Request and terminate inputs of other ports have no effect on it.
- R8: Channels ready for service are granted in fixed priority, lowest number first, one packet per grant.
- R9: Channel 0 keeps a reflected CRC-32 (polynomial 0xEDB88320, seed 0xFFFFFFFF) over the bytes it writes, least significant byte first. The seed is reloaded on start. Reading select 5 gives the bitwise complement of the running value.
- R10: Status bits 0 to 2 are sticky and are cleared by writing 1 to them. Writing 0 leaves them unchanged. Bit 3 reads busy.
- R11: A write strobe on the memory port only ever follows a read strobe in the cycle before. Read and write are never asserted together.
- R12: After reset, all channels are idle with zero status, and the memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address {channel, select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hw_req | input | 8 | Per-port packet request |
| hw_term | input | 8 | Per-port transfer terminate |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Packet width code (0=1, 1=2, 2=4 bytes) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_re |

## Verification
The copy function is exercised with four-byte packets with both addresses stepping, with mismatched width caps that force two-byte packets, and with single-byte packets into a fixed destination. These runs separate the width-selection, stepping and limit-compare paths. Device pacing is run first with only a foreign port active, then with its own request, then with its own terminate. This shows that the port index really selects. A mid-run enable clear shows the in-flight packet finishing before the abort. Two device-paced channels released in the same cycle show the grant order through the write address sequence. A known byte string on channel 0 checks the CRC against an independently computed value.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} xfer_st_e;

   localparam logic [31:0] CRC_POLY = 32'hEDB88320;

   // smaller of two width caps, code 3 treated as 4 bytes
   function automatic logic [1:0] eff_size(input logic [1:0] a, input logic [1:0] b);
      logic [1:0] ca;
      logic [1:0] cb;
      ca = (a == 2'd3) ? 2'd2 : a;
      cb = (b == 2'd3) ? 2'd2 : b;
      return (ca < cb) ? ca : cb;
   endfunction
endpackage

// File: rtl/dmx_arb.sv
module dmx_arb #(
   parameter int unsigned N = 7,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx
);
   for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == 0) begin : g_first
         assign grant[0] = req[0];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   // R8
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((req != '0) == (grant != '0)));
   // R8
   grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant - N'(1)) & req) == '0);
endmodule

// File: rtl/dmx_crc32.sv
module dmx_crc32 #(
   parameter logic [31:0] POLY = dmx_pkg::CRC_POLY
) (
   input  logic [31:0] crc_in,
   input  logic [31:0] data,
   input  logic [1:0]  code,
   output logic [31:0] crc_out
);
   function automatic logic [31:0] step8(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'b0, d};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
      return r;
   endfunction

   logic [31:0] lane_c [5];
   assign lane_c[0] = crc_in;
   for (genvar b = 0; b < 4; b++) begin : g_lane
      assign lane_c[b+1] = step8(lane_c[b], data[8*b +: 8]);
   end

   always_comb begin
      case (code)
         2'd0:    crc_out = lane_c[1];
         2'd1:    crc_out = lane_c[2];
         default: crc_out = lane_c[4];
      endcase
   end
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan #(
   parameter int unsigned AW = 32,
   parameter int unsigned NPORT = 8,
   localparam int unsigned PW = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int unsigned CTW = 9 + PW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_src,
   input  logic             wr_dst,
   input  logic             wr_lim,
   input  logic             wr_stat,
   input  logic [31:0]      wdata,
   input  logic             pkt_done,
   input  logic             inflight,
   input  logic [NPORT-1:0] hw_req,
   input  logic [NPORT-1:0] hw_term,
   output logic [CTW-1:0]   ctrl_rd,
   output logic [AW-1:0]    src_q,
   output logic [AW-1:0]    dst_q,
   output logic [AW-1:0]    lim_q,
   output logic [3:0]       stat_rd,
   output logic             req,
   output logic [1:0]       size_code
);
   logic en, hw, sinc, dinc, busy, f_done, f_abt, f_term;
   logic [1:0] scap, dcap;
   logic [PW-1:0] port;
   logic [AW-1:0] psz, src_nx, dst_nx, ref_nx;
   logic term_now, abort_now, hit;

   assign size_code = dmx_pkg::eff_size(scap, dcap);
   assign psz       = AW'(1) << size_code;
   assign src_nx    = sinc ? src_q + psz : src_q;
   assign dst_nx    = dinc ? dst_q + psz : dst_q;
   assign ref_nx    = sinc ? src_nx : dst_nx;
   assign hit       = ref_nx >= lim_q;
   assign term_now  = busy & hw & hw_term[port] & ~inflight;
   assign abort_now = busy & ~en & ~inflight;
   assign req       = busy & en & (hw ? (hw_req[port] & ~hw_term[port]) : 1'b1);
   assign ctrl_rd   = {port, dcap, scap, dinc, sinc, hw, 1'b0, en};
   assign stat_rd   = {busy, f_term, f_abt, f_done};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {en, hw, sinc, dinc, busy, f_done, f_abt, f_term} <= '0;
         scap <= '0;
         dcap <= '0;
         port <= '0;
         src_q <= '0;
         dst_q <= '0;
         lim_q <= '0;
      end else begin
         if (wr_ctrl) begin
            en   <= wdata[0];
            hw   <= wdata[2];
            sinc <= wdata[3];
            dinc <= wdata[4];
            scap <= wdata[6:5];
            dcap <= wdata[8:7];
            port <= wdata[9 +: PW];
            if (wdata[1] && wdata[0] && !busy) busy <= 1'b1;
         end
         if (wr_src) src_q <= wdata[AW-1:0];
         if (wr_dst) dst_q <= wdata[AW-1:0];
         if (wr_lim) lim_q <= wdata[AW-1:0];
         if (wr_stat) begin
            if (wdata[0]) f_done <= 1'b0;
            if (wdata[1]) f_abt  <= 1'b0;
            if (wdata[2]) f_term <= 1'b0;
         end
         if (pkt_done) begin
            src_q <= src_nx;
            dst_q <= dst_nx;
            if (hit) begin
               busy   <= 1'b0;
               f_done <= 1'b1;
            end
         end else if (term_now) begin
            busy   <= 1'b0;
            f_term <= 1'b1;
         end else if (abort_now) begin
            busy  <= 1'b0;
            f_abt <= 1'b1;
         end
      end
   end

   // R4
   busy_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (f_done || f_abt || f_term));
   // R3
   src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !sinc && !wr_src) |=> $stable(src_q));
   // R3
   src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && sinc) |=> (src_q == $past(src_q) + $past(psz)));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
   parameter int unsigned NCH = 7,
   parameter int unsigned NPORT = 8,
   parameter int unsigned AW = 32,
   localparam int unsigned CHW = $clog2(NCH),
   localparam int unsigned PW = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int unsigned RAW = CHW + 3,
   localparam int unsigned CTW = 9 + PW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [RAW-1:0]   reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [NPORT-1:0] hw_req,
   input  logic [NPORT-1:0] hw_term,
   output logic             mem_re,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [1:0]       mem_size,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata
);
   import dmx_pkg::*;

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("NCH out of range");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW out of range");
   end
   if (CTW > 32) begin : g_bad_port
      $error("NPORT too large for control word");
   end

   logic [CHW-1:0] rch, gidx, gnt_idx;
   logic [2:0]     rsel;
   xfer_st_e       st;
   logic [NCH-1:0] req_v, grant_v, pkt_done_v, inflight_v;
   logic [CTW-1:0] ctrl_a [NCH];
   logic [AW-1:0]  src_a [NCH];
   logic [AW-1:0]  dst_a [NCH];
   logic [AW-1:0]  lim_a [NCH];
   logic [3:0]     stat_a [NCH];
   logic [1:0]     size_a [NCH];
   logic [31:0]    crc_q, crc_nx;
   logic           c0_start;

   assign rch  = reg_addr[RAW-1:3];
   assign rsel = reg_addr[2:0];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel_c;
      assign sel_c         = reg_we && (rch == CHW'(c));
      assign pkt_done_v[c] = (st == ST_WR) && (gidx == CHW'(c));
      assign inflight_v[c] = (st != ST_IDLE) && (gidx == CHW'(c));
      dmx_chan #(.AW(AW), .NPORT(NPORT)) chan_i (
         .clk(clk), .rst_n(rst_n),
         .wr_ctrl(sel_c && rsel == 3'd0), .wr_src(sel_c && rsel == 3'd1),
         .wr_dst(sel_c && rsel == 3'd2), .wr_lim(sel_c && rsel == 3'd3),
         .wr_stat(sel_c && rsel == 3'd4), .wdata(reg_wdata),
         .pkt_done(pkt_done_v[c]), .inflight(inflight_v[c]),
         .hw_req(hw_req), .hw_term(hw_term),
         .ctrl_rd(ctrl_a[c]), .src_q(src_a[c]), .dst_q(dst_a[c]), .lim_q(lim_a[c]),
         .stat_rd(stat_a[c]), .req(req_v[c]), .size_code(size_a[c]));
   end

   dmx_arb #(.N(NCH)) arb_i (
      .clk(clk), .rst_n(rst_n), .req(req_v), .grant(grant_v), .idx(gnt_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         gidx <= '0;
      end else begin
         case (st)
            ST_IDLE: if (grant_v != '0) begin
               gidx <= gnt_idx;
               st   <= ST_RD;
            end
            ST_RD:   st <= ST_WR;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_re   = (st == ST_RD);
   assign mem_we   = (st == ST_WR);
   assign mem_addr = (st == ST_WR) ? dst_a[gidx] : src_a[gidx];
   assign mem_size = size_a[gidx];

   always_comb begin
      case (mem_size)
         2'd0:    mem_wdata = {24'b0, mem_rdata[7:0]};
         2'd1:    mem_wdata = {16'b0, mem_rdata[15:0]};
         default: mem_wdata = mem_rdata;
      endcase
   end

   dmx_crc32 crc_i (.crc_in(crc_q), .data(mem_wdata), .code(size_a[0]), .crc_out(crc_nx));

   assign c0_start = reg_we && (rch == '0) && (rsel == 3'd0) &&
                     reg_wdata[1] && reg_wdata[0] && !stat_a[0][3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             crc_q <= 32'hFFFF_FFFF;
      else if (c0_start)      crc_q <= 32'hFFFF_FFFF;
      else if (pkt_done_v[0]) crc_q <= crc_nx;
   end

   always_comb begin
      reg_rdata = '0;
      if (32'(rch) < NCH) begin
         case (rsel)
            3'd0: reg_rdata = 32'(ctrl_a[rch]);
            3'd1: reg_rdata = 32'(src_a[rch]);
            3'd2: reg_rdata = 32'(dst_a[rch]);
            3'd3: reg_rdata = 32'(lim_a[rch]);
            3'd4: reg_rdata = 32'(stat_a[rch]);
            3'd5: reg_rdata = (rch == '0) ? ~crc_q : '0;
            default: reg_rdata = '0;
         endcase
      end
   end

   // R11
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_re) && !mem_re));
   // R8
   grant_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req_v != '0) |=> mem_re);
   // R9
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_done_v[0] && !c0_start) |=> $stable(crc_q));
endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [5:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0] hw_req = '0;
   logic [7:0] hw_term = '0;
   logic mem_re, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [1:0] mem_size;
   logic [31:0] mem_rdata = '0;

   int errs = 0;
   int nchk = 0;
   int wcount = 0;
   int viol = 0;
   logic prev_re = 1'b0;
   logic [31:0] wlog [4];
   logic [7:0] mem [256];
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
      .hw_term(hw_term), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   always @(posedge clk) begin
      if (mem_re)
         mem_rdata <= {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                       mem[8'(mem_addr + 1)], mem[8'(mem_addr)]};
      if (mem_we) begin
         for (int k = 0; k < (1 << mem_size); k++)
            mem[8'(mem_addr + 32'(k))] <= mem_wdata[8*k +: 8];
         wcount <= wcount + 1;
         wlog[3] <= wlog[2];
         wlog[2] <= wlog[1];
         wlog[1] <= wlog[0];
         wlog[0] <= mem_addr;
         if (!prev_re || mem_re) viol <= viol + 1;
      end
      prev_re <= mem_re;
   end

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      nchk++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input int ch, input int sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1;
      reg_addr = 6'(ch * 8 + sel);
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int ch, input int sel, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 6'(ch * 8 + sel);
      #1 d = reg_rdata;
   endtask

   task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] l, input logic [31:0] ctrl);
      wr(ch, 1, s);
      wr(ch, 2, d);
      wr(ch, 3, l);
      wr(ch, 0, ctrl);
   endtask

   task automatic wait_idle(input int ch);
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(ch, 4, s);
         if (!s[3]) break;
      end
   endtask

   function automatic logic [31:0] crc_ref(input logic [31:0] base, input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c ^= {24'b0, mem[8'(base + 32'(i))]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      check({31'b0, mem_re | mem_we}, 0, "R12 memory strobes idle");
      for (int c = 0; c < 7; c++) begin
         rd(c, 4, v);
         check(v, 0, "R12 status after reset");
      end
   endtask

   task automatic t_copy4();
      logic [31:0] v;
      int c0;
      bit ok = 1'b1;
      c0 = wcount;
      setup(1, 32'h10, 32'h80, 32'h20, 32'h15B);
      wait_idle(1);
      check(32'(wcount - c0), 4, "R4 four 4-byte packets to limit");
      for (int i = 0; i < 16; i++) if (mem[8'h80 + i] !== mem[8'h10 + i]) ok = 1'b0;
      check({31'b0, ok}, 1, "R3 stepped copy contents");
      rd(1, 4, v);
      check(v, 32'h1, "R4 done bit");
      rd(1, 1, v);
      check(v, 32'h20, "R3 source advanced to limit");
   endtask

   task automatic t_sizemin();
      int c0;
      c0 = wcount;
      setup(2, 32'h20, 32'hA0, 32'h28, 32'hDB);
      wait_idle(2);
      check(32'(wcount - c0), 4, "R2 two-byte packets chosen");
      check({24'b0, mem[8'hA8]}, 0, "R2 no byte past limit");
      check({mem[8'hA7], mem[8'hA0]}, {mem[8'h27], mem[8'h20]}, "R2 copy data");
   endtask

   task automatic t_fixed();
      logic [31:0] v;
      setup(3, 32'h30, 32'hC0, 32'h34, 32'h0B);
      wait_idle(3);
      rd(3, 2, v);
      check(v, 32'hC0, "R3 fixed destination");
      check({24'b0, mem[8'hC0]}, {24'b0, mem[8'h33]}, "R3 last byte at fixed address");
      check({24'b0, mem[8'hC1]}, 0, "R3 neighbour untouched");
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(1, 4, 32'h0);
      rd(1, 4, v);
      check(v, 32'h1, "R10 write 0 keeps done");
      wr(1, 4, 32'h1);
      rd(1, 4, v);
      check(v, 32'h0, "R10 write 1 clears done");
   endtask

   task automatic t_hw();
      logic [31:0] v;
      int c0, c1;
      c0 = wcount;
      setup(4, 32'h40, 32'hD0, 32'h80, 32'hA1F);
      hw_req = 8'h10;
      hw_term = 8'h10;
      repeat (30) @(negedge clk);
      check(32'(wcount - c0), 0, "R7 other port ignored");
      rd(4, 4, v);
      check(v, 32'h8, "R7 still busy without own request");
      hw_term = 8'h00;
      hw_req = 8'h20;
      repeat (12) @(negedge clk);
      hw_req = 8'h00;
      repeat (4) @(negedge clk);
      c1 = wcount;
      check({31'b0, c1 > c0}, 1, "R7 packets with own request");
      repeat (20) @(negedge clk);
      check(32'(wcount), 32'(c1), "R7 pause when request drops");
      hw_term = 8'h20;
      repeat (3) @(negedge clk);
      hw_term = 8'h00;
      rd(4, 4, v);
      check(v, 32'h4, "R6 terminated by device");
   endtask

   task automatic t_abort();
      logic [31:0] v;
      int c0, c1;
      c0 = wcount;
      setup(5, 32'h00, 32'hE0, 32'hFF, 32'h1B);
      repeat (10) @(negedge clk);
      wr(5, 0, 32'h18);
      repeat (10) @(negedge clk);
      rd(5, 4, v);
      check(v, 32'h2, "R5 aborted and idle");
      c1 = wcount;
      repeat (20) @(negedge clk);
      check(32'(wcount), 32'(c1), "R5 no packet after abort");
      rd(5, 2, v);
      check(v - 32'hE0, 32'(c1 - c0), "R5 in-flight packet completed");
   endtask

   task automatic t_prio();
      logic [31:0] v;
      wr(5, 4, 32'h7);
      setup(5, 32'h00, 32'h60, 32'h02, 32'h41F);
      setup(6, 32'h04, 32'h70, 32'h06, 32'h61F);
      hw_req = 8'h0C;
      repeat (20) @(negedge clk);
      hw_req = 8'h00;
      check(wlog[3], 32'h60, "R8 lower channel first");
      check(wlog[2], 32'h61, "R8 lower channel second packet");
      check(wlog[1], 32'h70, "R8 higher channel after");
      check(wlog[0], 32'h71, "R8 higher channel last");
      rd(6, 3, v);
      check(v, 32'h06, "R1 limit readback");
      rd(6, 0, v);
      check(v, 32'h61D, "R1 control readback");
   endtask

   task automatic t_crc();
      logic [31:0] v;
      for (int i = 0; i < 8; i++) mem[8'h90 + i] = 8'h31 + 8'(i);
      setup(0, 32'h90, 32'hB0, 32'h98, 32'h15B);
      wait_idle(0);
      rd(0, 5, v);
      check(v, crc_ref(32'h90, 8), "R9 CRC over eight bytes");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'(i * 7 + 3) : 8'h00;
      for (int i = 0; i < 4; i++) wlog[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_copy4();
      t_sizemin();
      t_fixed();
      t_w1c();
      t_hw();
      t_abort();
      t_prio();
      t_crc();
      check(32'(viol), 0, "R11 write always follows read");
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, nchk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         errs++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, nchk);
         $finish;
      end
   end
endmodule